// File: doc/BRIEF.md
# Video Sync Mode Detector

This block takes the horizontal and vertical sync lines of an analog-style video input and works out which video mode is arriving. Both lines are brought into the reference clock domain, and the polarity of each is found and normalized. A free-running reference clock then times the spacing of horizontal sync pulses, and the block counts how many of those pulses fall between two vertical sync pulses. The line rate alone cannot tell modes apart, because several modes share one horizontal frequency, so the line count per frame is always used alongside it.

The two measurements are compared against a parameter table of known modes, and the nearest acceptable entry wins. Once the same entry has won for three frames in a row, the block reports that entry's index and its total clocks per line. The total includes blanking, so it is larger than the active width. This value is what an external pixel-clock PLL needs as its feedback divider. The default table holds four common 60 Hz desktop modes for a 125 MHz reference. One of them is the 1280x960 mode, with 1800 clocks per line and 1000 lines per frame.

Top module: `sync_mode_detect`

## Requirements
- R1: Each sync input passes through a two-flop synchronizer. The polarity of each line is decided separately, once per period of that raw line. The line is treated as active-low when its high time exceeds its low time. The active edge is the start of the sync pulse in either polarity.
- R2: The line period is the number of reference clocks between consecutive active horizontal edges. The line count is the number of active horizontal edges from one active vertical edge up to, but not including, the next. An edge that coincides with a vertical edge belongs to the new frame.
- R3: The cost of a table entry is |period error| + LINE_WEIGHT x |line-count error|. The accepted entry with the lowest cost is the best match. On equal cost, the lower table index wins.
- R4: An entry is rejected when 50 x |period error| exceeds its table period. An error of exactly 2 percent is still accepted. When every entry is rejected, there is no best match.
- R5: Two entries that share one line period are told apart by their line counts.
- R6: Matching is evaluated at each active vertical edge. mode_valid rises at the third consecutive evaluation that returns the same best match. It falls at the first evaluation that returns a different entry or no match.
- R7: If VS_TIMEOUT reference clocks pass without an active vertical edge, mode_valid falls and the period, line count and match history are cleared. After that, three fresh frames are needed before mode_valid rises again.
- R8: While mode_valid is 1, mode_idx is the winning table index and pll_div is that entry's total clocks per line. While mode_valid is 0, including after reset, mode_idx and pll_div are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, either polarity |
| vsync_in | input | 1 | Vertical sync, either polarity |
| mode_valid | output | 1 | Detected mode is stable |
| mode_idx | output | IDX_W | Table index of detected mode |
| pll_div | output | DIV_W | Total clocks per line of detected mode |

## Verification
The assertions assume that sync pulses are shorter than half their own period. This lets the duty comparison settle on the true polarity. They also assume that a frame is shorter than VS_TIMEOUT, so the loss detector does not fire during normal video. The stimulus generates both lines from one line and frame counter. It uses pulses of four clocks and two lines, periods of 40 to 60 clocks, and frames of at most 20 lines, against a timeout of 3000 clocks. Every polarity change and mode change is followed by enough frames to settle before any check is made.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

  // reciprocal of the allowed line-period error (1/50 = 2 percent)
  localparam logic [31:0] TOL_RECIP = 32'd50;

  function automatic logic [31:0] abs_diff(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [31:0] mode_cost(input logic [31:0] per, input logic [31:0] lines,
                                            input logic [31:0] ref_per, input logic [31:0] ref_lines,
                                            input logic [31:0] weight);
    return abs_diff(per, ref_per) + weight * abs_diff(lines, ref_lines);
  endfunction

  function automatic logic period_in_tol(input logic [31:0] per, input logic [31:0] ref_per);
    return (abs_diff(per, ref_per) * TOL_RECIP) <= ref_per;
  endfunction

endpackage

// File: rtl/sync_polarity.sv
module sync_polarity #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  output logic act_edge
);
  logic [1:0]       meta_q;
  logic             raw_prev_q;
  logic             inv_q;
  logic             norm_prev_q;
  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W-1:0] lo_cnt;
  logic             s_sync;
  logic             raw_rise;
  logic             norm;

  assign s_sync   = meta_q[1];
  assign raw_rise = s_sync & ~raw_prev_q;
  assign norm     = s_sync ^ inv_q;
  assign act_edge = norm & ~norm_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q      <= '0;
      raw_prev_q  <= 1'b0;
      inv_q       <= 1'b0;
      norm_prev_q <= 1'b0;
      hi_cnt      <= '0;
      lo_cnt      <= '0;
    end else begin
      meta_q      <= {meta_q[0], sync_raw};
      raw_prev_q  <= s_sync;
      norm_prev_q <= norm;
      if (raw_rise) begin
        inv_q  <= (hi_cnt > lo_cnt);
        hi_cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
        lo_cnt <= '0;
      end else if (s_sync) begin
        if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    act_edge |=> !act_edge); // R1

endmodule

// File: rtl/line_meter.sv
module line_meter #(
  parameter int PER_W      = 16,
  parameter int LINE_W     = 12,
  parameter int VS_TIMEOUT = 4000000,
  localparam int TO_W      = $clog2(VS_TIMEOUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_edge,
  input  logic              vs_edge,
  output logic [PER_W-1:0]  line_period,
  output logic [LINE_W-1:0] line_count,
  output logic              sync_lost
);
  localparam logic [TO_W-1:0] TO_LIM = TO_W'(VS_TIMEOUT - 1);

  logic [PER_W-1:0] per_cnt;
  logic [TO_W-1:0]  to_cnt;

  assign sync_lost = (to_cnt == TO_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt     <= '0;
      to_cnt      <= '0;
      line_period <= '0;
      line_count  <= '0;
    end else if (sync_lost) begin
      per_cnt     <= '0;
      to_cnt      <= '0;
      line_period <= '0;
      line_count  <= '0;
    end else begin
      if (vs_edge) to_cnt <= '0;
      else         to_cnt <= to_cnt + 1'b1;

      if (hs_edge) begin
        line_period <= (per_cnt == '1) ? per_cnt : per_cnt + 1'b1;
        per_cnt     <= '0;
      end else if (per_cnt != '1) begin
        per_cnt <= per_cnt + 1'b1;
      end

      if (vs_edge)
        line_count <= {{(LINE_W-1){1'b0}}, hs_edge};
      else if (hs_edge && line_count != '1)
        line_count <= line_count + 1'b1;
    end
  end

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_edge && !vs_edge && !sync_lost) |=> $stable(line_count)); // R2
  AST_LOST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> (line_period == '0 && line_count == '0)); // R7

endmodule

// File: rtl/mode_matcher.sv
module mode_matcher
  import sync_mode_pkg::*;
#(
  parameter int NUM_MODES   = 4,
  parameter int PER_W       = 16,
  parameter int LINE_W      = 12,
  parameter int LINE_WEIGHT = 4,
  parameter logic [NUM_MODES*PER_W-1:0]  TBL_PERIOD = '0,
  parameter logic [NUM_MODES*LINE_W-1:0] TBL_LINES  = '0,
  localparam int IDX_W = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  period,
  input  logic [LINE_W-1:0] lines,
  output logic [IDX_W-1:0]  best_idx,
  output logic              best_ok
);
  logic [31:0] cost    [NUM_MODES];
  logic        cand_ok [NUM_MODES];
  logic [31:0] best_cost;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_cand
    assign cost[g]    = mode_cost(32'(period), 32'(lines),
                                  32'(TBL_PERIOD[g*PER_W +: PER_W]),
                                  32'(TBL_LINES[g*LINE_W +: LINE_W]),
                                  32'(LINE_WEIGHT));
    assign cand_ok[g] = period_in_tol(32'(period), 32'(TBL_PERIOD[g*PER_W +: PER_W]));
  end

  always_comb begin
    best_ok   = 1'b0;
    best_idx  = '0;
    best_cost = '1;
    for (int i = 0; i < NUM_MODES; i++) begin
      if (cand_ok[i] && (!best_ok || cost[i] < best_cost)) begin
        best_ok   = 1'b1;
        best_idx  = IDX_W'(i);
        best_cost = cost[i];
      end
    end
  end

  AST_WINNER_IN_TOL: assert property (@(posedge clk) disable iff (!rst_n)
    best_ok |-> period_in_tol(32'(period), 32'(TBL_PERIOD[best_idx*PER_W +: PER_W]))); // R4

endmodule

// File: rtl/sync_mode_detect.sv
module sync_mode_detect #(
  parameter int NUM_MODES     = 4,
  parameter int PER_W         = 16,
  parameter int LINE_W        = 12,
  parameter int DIV_W         = 12,
  parameter int LINE_WEIGHT   = 4,
  parameter int STABLE_FRAMES = 3,
  parameter int VS_TIMEOUT    = 4000000,
  parameter logic [NUM_MODES*PER_W-1:0]  TBL_PERIOD = {16'd2083, 16'd2585, 16'd3300, 16'd3972},
  parameter logic [NUM_MODES*LINE_W-1:0] TBL_LINES  = {12'd1000, 12'd806, 12'd628, 12'd525},
  parameter logic [NUM_MODES*DIV_W-1:0]  TBL_DIV    = {12'd1800, 12'd1344, 12'd1056, 12'd800},
  localparam int IDX_W = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  output logic             mode_valid,
  output logic [IDX_W-1:0] mode_idx,
  output logic [DIV_W-1:0] pll_div
);
  localparam int TO_W   = $clog2(VS_TIMEOUT + 1);
  localparam int STAB_W = $clog2(STABLE_FRAMES + 1);
  localparam logic [STAB_W-1:0] STAB_LIM = STAB_W'(STABLE_FRAMES);

  logic              hs_edge;
  logic              vs_edge;
  logic              sync_lost;
  logic [PER_W-1:0]  line_period;
  logic [LINE_W-1:0] line_count;
  logic [IDX_W-1:0]  best_idx;
  logic              best_ok;
  logic [STAB_W-1:0] run_cnt;
  logic [STAB_W-1:0] run_nxt;
  logic [IDX_W-1:0]  last_idx;
  logic [DIV_W-1:0]  div_q;
  logic              valid_q;

  sync_polarity #(.CNT_W(PER_W)) u_hpol (
    .clk(clk), .rst_n(rst_n), .sync_raw(hsync_in), .act_edge(hs_edge));

  sync_polarity #(.CNT_W(TO_W)) u_vpol (
    .clk(clk), .rst_n(rst_n), .sync_raw(vsync_in), .act_edge(vs_edge));

  line_meter #(.PER_W(PER_W), .LINE_W(LINE_W), .VS_TIMEOUT(VS_TIMEOUT)) u_meter (
    .clk(clk), .rst_n(rst_n), .hs_edge(hs_edge), .vs_edge(vs_edge),
    .line_period(line_period), .line_count(line_count), .sync_lost(sync_lost));

  mode_matcher #(
    .NUM_MODES(NUM_MODES), .PER_W(PER_W), .LINE_W(LINE_W), .LINE_WEIGHT(LINE_WEIGHT),
    .TBL_PERIOD(TBL_PERIOD), .TBL_LINES(TBL_LINES)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .period(line_period), .lines(line_count),
    .best_idx(best_idx), .best_ok(best_ok));

  assign run_nxt = (run_cnt == STAB_LIM) ? STAB_LIM : run_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      last_idx <= '0;
      div_q    <= '0;
      valid_q  <= 1'b0;
    end else if (sync_lost) begin
      run_cnt  <= '0;
      last_idx <= '0;
      div_q    <= '0;
      valid_q  <= 1'b0;
    end else if (vs_edge) begin
      if (!best_ok) begin
        run_cnt <= '0;
        valid_q <= 1'b0;
        div_q   <= '0;
      end else if (run_cnt != '0 && best_idx == last_idx) begin
        run_cnt <= run_nxt;
        valid_q <= (run_nxt == STAB_LIM);
      end else begin
        run_cnt <= STAB_W'(1);
        valid_q <= (STAB_LIM == STAB_W'(1));
      end
      last_idx <= best_idx;
      if (best_ok) div_q <= TBL_DIV[best_idx*DIV_W +: DIV_W];
    end
  end

  assign mode_valid = valid_q;
  assign mode_idx   = valid_q ? last_idx : '0;
  assign pll_div    = valid_q ? div_q : '0;

  AST_VALID_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_valid) |-> $past(vs_edge)); // R6
  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && $past(mode_valid)) |-> $stable(mode_idx)); // R6
  AST_LOST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> !mode_valid); // R7
  AST_VALID_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_edge && !best_ok && !sync_lost) |=> !mode_valid); // R4

endmodule

// File: tb/tb_sync_mode_detect.sv
module tb_sync_mode_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs = 1'b0;
  logic       vs = 1'b0;
  logic       mode_valid;
  logic [1:0] mode_idx;
  logic [11:0] pll_div;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sync_mode_detect #(
    .NUM_MODES(4), .PER_W(16), .LINE_W(12), .DIV_W(12), .LINE_WEIGHT(4),
    .STABLE_FRAMES(3), .VS_TIMEOUT(3000),
    .TBL_PERIOD({16'd50, 16'd60, 16'd40, 16'd40}),
    .TBL_LINES ({12'd20, 12'd12, 12'd16, 12'd12}),
    .TBL_DIV   ({12'd1800, 12'd1344, 12'd1056, 12'd800})
  ) dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs),
    .mode_valid(mode_valid), .mode_idx(mode_idx), .pll_div(pll_div));

  typedef struct packed {
    logic [15:0] per;
    logic [11:0] lines;
    logic        hp;
    logic        vp;
    logic        ev;
    logic [1:0]  eidx;
    logic [11:0] ediv;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{16'd40, 12'd12, 1'b1, 1'b1, 1'b1, 2'd0, 12'd800},   // R2 exact mode 0
    '{16'd40, 12'd16, 1'b1, 1'b1, 1'b1, 2'd1, 12'd1056},  // R5 same period, more lines
    '{16'd60, 12'd12, 1'b0, 1'b1, 1'b1, 2'd2, 12'd1344},  // R1 active-low hsync
    '{16'd50, 12'd20, 1'b0, 1'b0, 1'b1, 2'd3, 12'd1800},  // R1 both active-low
    '{16'd40, 12'd13, 1'b1, 1'b0, 1'b1, 2'd0, 12'd800},   // R3 nearest by lines
    '{16'd40, 12'd14, 1'b1, 1'b1, 1'b1, 2'd0, 12'd800},   // R3 tie to lower index
    '{16'd40, 12'd15, 1'b1, 1'b1, 1'b1, 2'd1, 12'd1056},  // R3 nearest by lines
    '{16'd51, 12'd20, 1'b1, 1'b1, 1'b1, 2'd3, 12'd1800},  // R4 exactly 2 percent
    '{16'd41, 12'd12, 1'b1, 1'b1, 1'b0, 2'd0, 12'd0}      // R4 all rejected
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frames(input int per, input int lines, input bit hp, input bit vp, input int nfr);
    for (int f = 0; f < nfr; f++)
      for (int l = 0; l < lines; l++)
        for (int c = 0; c < per; c++) begin
          @(negedge clk);
          hs = (c < 4) ? hp : ~hp;
          vs = (l < 2) ? vp : ~vp;
        end
  endtask

  task automatic idle(input int n, input bit hp, input bit vp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hs = ~hp;
      vs = ~vp;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8 reset state
    chk("R8 reset valid", 32'(mode_valid), 0);
    chk("R8 reset idx", 32'(mode_idx), 0);
    chk("R8 reset div", 32'(pll_div), 0);
    rst_n = 1'b1;
    idle(10, 1'b1, 1'b1);

    // R6 three frames needed
    run_frames(40, 12, 1'b1, 1'b1, 3);
    chk("R6 not yet valid after two matches", 32'(mode_valid), 0);
    chk("R8 div zero while invalid", 32'(pll_div), 0);
    run_frames(40, 12, 1'b1, 1'b1, 1);
    chk("R6 valid after third match", 32'(mode_valid), 1);
    chk("R8 idx", 32'(mode_idx), 0);
    chk("R8 div", 32'(pll_div), 800);

    // R6 change of best match drops valid
    run_frames(40, 16, 1'b1, 1'b1, 2);
    chk("R6 valid dropped on change", 32'(mode_valid), 0);
    run_frames(40, 16, 1'b1, 1'b1, 2);
    chk("R6 valid again on new mode", 32'(mode_valid), 1);
    chk("R5 idx by line count", 32'(mode_idx), 1);

    // R7 timeout
    idle(3200, 1'b1, 1'b1);
    chk("R7 valid dropped on timeout", 32'(mode_valid), 0);
    chk("R7 div cleared on timeout", 32'(pll_div), 0);
    run_frames(40, 12, 1'b1, 1'b1, 3);
    chk("R7 fresh frames needed", 32'(mode_valid), 0);
    run_frames(40, 12, 1'b1, 1'b1, 1);
    chk("R7 reacquired", 32'(mode_valid), 1);

    // R1 R2 R3 R4 R5 vector table
    for (int k = 0; k < NVEC; k++) begin
      run_frames(int'(VECS[k].per), int'(VECS[k].lines), VECS[k].hp, VECS[k].vp, 7);
      chk($sformatf("R1 R2 R3 R4 R5 vec%0d valid", k), 32'(mode_valid), 32'(VECS[k].ev));
      chk($sformatf("R3 R8 vec%0d idx", k), 32'(mode_idx), 32'(VECS[k].eidx));
      chk($sformatf("R8 vec%0d div", k), 32'(pll_div), 32'(VECS[k].ediv));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule